// File: doc/BRIEF.md
# Generic PECI Command Sequencer

This block holds one host-programmed PECI transaction and plays it out as a byte stream to a bit-level line transmitter. The host loads a client address, a write length, a read length and up to thirteen write bytes through a small register port, then sets a start bit. The engine sends the header and the data, generates and appends the write-phase frame check byte itself, and then collects the client's reply into a nine-byte read buffer. The host reads the reply from that buffer.

The control sits in one state machine. Its states are IDLE (waiting), ADDR, WLEN and RLEN (the three header bytes), DATA (write buffer bytes), FCS (the generated check byte), RECV (collecting reply bytes) and DONE (a one-cycle completion state). The transitions are as follows. IDLE or DONE goes to ADDR on an accepted start, and DONE otherwise goes to IDLE. ADDR goes to WLEN, and WLEN to RLEN, each on a transmit handshake. RLEN goes to DATA when the write length is at least 2, to FCS when it is 1, and straight to the read phase when it is 0. DATA loops until its last byte and then goes to FCS. FCS goes to the read phase. The read phase is RECV when the read length is non-zero and DONE when it is zero. RECV goes to DONE once the last reply byte is stored.

Top module: `peci_cmd_engine`

## Requirements
- R1: After reset busy, done, err and tx_valid are 0, and every register reads 0.
- R2: Register map on reg_addr: 0 client address, 1 write length, 2 read length, 3..15 write buffer bytes 0..12, 16..24 read buffer bytes 0..8 (host writes there are ignored), 25 control. A control write with bit 0 set is a start request. A control read returns {5'b0, err, done, busy}.
- R3: A start with write length above 14 or read length above 9 sets err, sends nothing and leaves busy at 0. An accepted start clears err.
- R4: The frame is sent in this order: client address, write length, read length, write buffer bytes 0 to (write length − 2), then the check byte. The first write buffer byte is the command code.
- R5: The check byte is CRC-8 with polynomial 0x07, initial value 0x00, processed MSB first and without reflection or final XOR. It covers the address, both length bytes and every data byte sent.
- R6: A write length of 0 sends only the three header bytes, with no data byte and no check byte.
- R7: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value.
- R8: After the write phase, each cycle with rx_valid high stores rx_data into the next read buffer slot, starting at slot 0, until read-length bytes are stored. Slots beyond that keep their old values. rx_valid outside the read phase is ignored.
- R9: busy rises in the cycle after an accepted start and stays high until the last reply byte is stored. done is then high for exactly one cycle, with busy low.
- R10: Host register writes and start requests made while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_data | output | 8 | Byte offered to the line transmitter |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| rx_data | input | 8 | Byte received from the client |
| rx_valid | input | 1 | rx_data is valid this cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start request rejected for length |

## Verification
The assertions assume that the line transmitter only raises tx_ready as a plain acceptance signal. They also assume the host does not expect register writes to take effect while busy is high. Beyond that, they rely only on the lengths held in the registers. They assume that rx_valid pulses arrive one byte per cycle and carry nothing but reply bytes once the write phase ends. The bench sweeps every write length from 0 to 14 against several read lengths, with and without transmitter stalls. It sends reply bytes only after it has counted every expected transmit byte, and it injects junk rx_valid pulses only before that point.

// File: rtl/peci_eng_pkg.sv
package peci_eng_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_WLEN,
        S_RLEN,
        S_DATA,
        S_FCS,
        S_RECV,
        S_DONE
    } eng_state_t;

    localparam logic [7:0] FCS_POLY = 8'h07;
    localparam logic [7:0] FCS_INIT = 8'h00;

endpackage

// File: rtl/peci_crc8.sv
module peci_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] byte_in,
    output logic [7:0] crc_out
);
    always_comb begin
        logic [7:0] acc;
        acc = crc_in ^ byte_in;
        for (int b = 0; b < 8; b++) begin
            acc = acc[7] ? ((acc << 1) ^ POLY) : (acc << 1);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/peci_regs.sv
module peci_regs #(
    parameter int WBUF = 13,
    parameter int RBUF = 9,
    parameter int AW   = 5,
    localparam int RIW = $clog2(RBUF)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [AW-1:0]         reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  busy,
    input  logic                  done,
    input  logic                  err,
    output logic                  start_req,
    output logic [7:0]            tgt,
    output logic [7:0]            wlen,
    output logic [7:0]            rlen,
    output logic [WBUF-1:0][7:0]  wbuf,
    input  logic                  rb_we,
    input  logic [RIW-1:0]        rb_idx,
    input  logic [7:0]            rb_data
);
    localparam int A_TGT  = 0;
    localparam int A_WLEN = 1;
    localparam int A_RLEN = 2;
    localparam int A_WB   = 3;
    localparam int A_RB   = A_WB + WBUF;
    localparam int A_CTL  = A_RB + RBUF;

    logic [RBUF-1:0][7:0] rbuf;
    logic                 host_we;
    int                   aidx;

    assign aidx    = int'(reg_addr);
    assign host_we = reg_wr && !busy;
    assign start_req = host_we && (aidx == A_CTL) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt  <= '0;
            wlen <= '0;
            rlen <= '0;
        end else if (host_we) begin
            if (aidx == A_TGT)  tgt  <= reg_wdata;
            if (aidx == A_WLEN) wlen <= reg_wdata;
            if (aidx == A_RLEN) rlen <= reg_wdata;
        end
    end

    for (genvar g = 0; g < WBUF; g++) begin : g_wbuf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              wbuf[g] <= '0;
            else if (host_we && aidx == A_WB + g)    wbuf[g] <= reg_wdata;
        end
    end

    for (genvar g = 0; g < RBUF; g++) begin : g_rbuf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              rbuf[g] <= '0;
            else if (rb_we && int'(rb_idx) == g)     rbuf[g] <= rb_data;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (aidx == A_TGT)       reg_rdata = tgt;
        else if (aidx == A_WLEN) reg_rdata = wlen;
        else if (aidx == A_RLEN) reg_rdata = rlen;
        else if (aidx == A_CTL)  reg_rdata = {5'b0, err, done, busy};
        else begin
            for (int i = 0; i < WBUF; i++)
                if (aidx == A_WB + i) reg_rdata = wbuf[i];
            for (int i = 0; i < RBUF; i++)
                if (aidx == A_RB + i) reg_rdata = rbuf[i];
        end
    end

    // R10: the frame setup cannot move under a running transaction
    assert_setup_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(tgt) && $stable(wlen) && $stable(rlen)) || !busy);

    // R8: reply bytes land only inside the programmed read length
    assert_rb_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rb_we |-> (8'(rb_idx) < rlen));

endmodule

// File: rtl/peci_seq.sv
module peci_seq
    import peci_eng_pkg::*;
#(
    parameter int WBUF = 13,
    parameter int RBUF = 9,
    localparam int WIW = $clog2(WBUF),
    localparam int RIW = $clog2(RBUF),
    localparam int WLEN_MAX = WBUF + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_req,
    input  logic [7:0]            tgt,
    input  logic [7:0]            wlen,
    input  logic [7:0]            rlen,
    input  logic [WBUF-1:0][7:0]  wbuf,
    output logic [7:0]            tx_data,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    input  logic [7:0]            rx_data,
    input  logic                  rx_valid,
    output logic                  rb_we,
    output logic [RIW-1:0]        rb_idx,
    output logic [7:0]            rb_data,
    output logic                  busy,
    output logic                  done,
    output logic                  err
);
    eng_state_t     state_q, state_d;
    logic [WIW-1:0] widx_q, widx_d;
    logic [RIW-1:0] ridx_q, ridx_d;
    logic [7:0]     crc_q, crc_d, crc_step;
    logic           err_q, err_d;
    logic           len_bad, launch, tx_fire;
    eng_state_t     after_write;

    assign len_bad = (wlen > 8'(WLEN_MAX)) || (rlen > 8'(RBUF));
    assign launch  = start_req && (state_q == S_IDLE || state_q == S_DONE);
    assign after_write = (rlen == 8'd0) ? S_DONE : S_RECV;

    peci_crc8 #(.POLY(FCS_POLY)) u_crc (
        .crc_in  (crc_q),
        .byte_in (tx_data),
        .crc_out (crc_step)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            widx_q  <= '0;
            ridx_q  <= '0;
            crc_q   <= FCS_INIT;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            widx_q  <= widx_d;
            ridx_q  <= ridx_d;
            crc_q   <= crc_d;
            err_q   <= err_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        widx_d  = widx_q;
        ridx_d  = ridx_q;
        crc_d   = crc_q;
        err_d   = err_q;
        tx_fire = tx_valid && tx_ready;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                state_d = S_IDLE;
                if (launch) begin
                    err_d = len_bad;
                    if (!len_bad) begin
                        state_d = S_ADDR;
                        crc_d   = FCS_INIT;
                        widx_d  = '0;
                        ridx_d  = '0;
                    end
                end
            end
            S_ADDR: if (tx_fire) begin
                crc_d   = crc_step;
                state_d = S_WLEN;
            end
            S_WLEN: if (tx_fire) begin
                crc_d   = crc_step;
                state_d = S_RLEN;
            end
            S_RLEN: if (tx_fire) begin
                crc_d = crc_step;
                if (wlen == 8'd0)      state_d = after_write;
                else if (wlen == 8'd1) state_d = S_FCS;
                else                   state_d = S_DATA;
            end
            S_DATA: if (tx_fire) begin
                crc_d = crc_step;
                if (8'(widx_q) == wlen - 8'd2) state_d = S_FCS;
                else                           widx_d  = widx_q + 1'b1;
            end
            S_FCS: if (tx_fire) state_d = after_write;
            S_RECV: if (rx_valid) begin
                ridx_d = ridx_q + 1'b1;
                if (8'(ridx_q) == rlen - 8'd1) state_d = S_DONE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = '0;
        rb_we    = 1'b0;
        unique case (state_q)
            S_ADDR: begin tx_valid = 1'b1; tx_data = tgt;          end
            S_WLEN: begin tx_valid = 1'b1; tx_data = wlen;         end
            S_RLEN: begin tx_valid = 1'b1; tx_data = rlen;         end
            S_DATA: begin tx_valid = 1'b1; tx_data = wbuf[widx_q]; end
            S_FCS:  begin tx_valid = 1'b1; tx_data = crc_q;        end
            S_RECV: rb_we = rx_valid;
            default: ;
        endcase
    end

    assign rb_idx  = ridx_q;
    assign rb_data = rx_data;
    assign busy    = (state_q != S_IDLE) && (state_q != S_DONE);
    assign done    = (state_q == S_DONE);
    assign err     = err_q;

    // R7: an offered byte is held until the transmitter takes it
    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R9: done is a single-cycle pulse and never overlaps busy
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: a rejected start leaves the engine idle with err raised
    assert_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !busy && len_bad) |=> (err && !busy && !tx_valid));

    // R3: every transaction that runs was started with legal lengths
    assert_legal_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !len_bad);

    // R8: no reply byte is stored while a frame byte is still on offer
    assert_no_early_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rb_we);

endmodule

// File: rtl/peci_cmd_engine.sv
module peci_cmd_engine #(
    parameter int WBUF = 13,
    parameter int RBUF = 9,
    localparam int NREG = 3 + WBUF + RBUF + 1,
    localparam int AW   = $clog2(NREG),
    localparam int RIW  = $clog2(RBUF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    input  logic [7:0]    rx_data,
    input  logic          rx_valid,
    output logic          busy,
    output logic          done,
    output logic          err
);
    logic                 start_req;
    logic [7:0]           tgt, wlen, rlen;
    logic [WBUF-1:0][7:0] wbuf;
    logic                 rb_we;
    logic [RIW-1:0]       rb_idx;
    logic [7:0]           rb_data;

    peci_regs #(.WBUF(WBUF), .RBUF(RBUF), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .start_req (start_req),
        .tgt       (tgt),
        .wlen      (wlen),
        .rlen      (rlen),
        .wbuf      (wbuf),
        .rb_we     (rb_we),
        .rb_idx    (rb_idx),
        .rb_data   (rb_data)
    );

    peci_seq #(.WBUF(WBUF), .RBUF(RBUF)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .tgt       (tgt),
        .wlen      (wlen),
        .rlen      (rlen),
        .wbuf      (wbuf),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rb_we     (rb_we),
        .rb_idx    (rb_idx),
        .rb_data   (rb_data),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

endmodule

// File: tb/test_peci_cmd_engine.sv
module test_peci_cmd_engine;
    localparam int A_WB  = 3;
    localparam int A_RB  = 16;
    localparam int A_CTL = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic       busy, done, err;

    int checks = 0;
    int errors = 0;
    logic [7:0] rb_model [9];

    always #10 clk = ~clk;

    peci_cmd_engine i_peci_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .busy(busy), .done(done), .err(err)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_upd(logic [7:0] c, logic [7:0] d);
        logic [7:0] x = c ^ d;
        for (int b = 0; b < 8; b++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    function automatic logic [7:0] wpat(int wl, int i);
        return 8'((wl * 37 + i * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] rpat(int wl, int rl, int j);
        return 8'((rl * 13 + j * 29 + wl + 1) & 255);
    endfunction

    task automatic reg_write(int a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(int a, output logic [7:0] d);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    task automatic run_txn(int wl, int rl, bit stall, bit poke);
        logic [7:0] exp_q [$];
        logic [7:0] c, rd, held_d;
        int ntx, nrx, nexp;
        bit held, in_rx;
        reg_write(0, 8'(8'h30 + wl));
        reg_write(1, 8'(wl));
        reg_write(2, 8'(rl));
        for (int i = 0; i < 13; i++) reg_write(A_WB + i, wpat(wl, i));
        reg_read(0, rd);  check("R2 tgt readback", rd, 8'h30 + wl);
        reg_read(1, rd);  check("R2 wlen readback", rd, wl);
        reg_read(A_WB + 12, rd); check("R2 wbuf readback", rd, wpat(wl, 12));
        exp_q.push_back(8'(8'h30 + wl));
        exp_q.push_back(8'(wl));
        exp_q.push_back(8'(rl));
        for (int i = 0; i + 1 < wl; i++) exp_q.push_back(wpat(wl, i));
        c = 8'h00;
        foreach (exp_q[k]) c = crc_upd(c, exp_q[k]);
        if (wl > 0) exp_q.push_back(c);   // R5 check byte, R6 none when wl==0
        nexp = exp_q.size();
        reg_write(A_CTL, 8'h01);
        check("R9 busy after start", busy, 1);
        ntx = 0; nrx = 0; held = 0; held_d = '0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            in_rx = (ntx == nexp);
            tx_ready = stall ? (cyc % 3 != 1) : 1'b1;
            reg_wr = 1'b0;
            if (poke && cyc == 1) begin
                reg_wr = 1'b1; reg_addr = 5'(A_WB); reg_wdata = ~wpat(wl, 0);
            end
            if (!in_rx) begin
                rx_valid = 1'b1; rx_data = 8'hEE;          // R8 junk, ignored
            end else begin
                rx_valid = (nrx < rl) && (cyc % 2 == 0);
                rx_data = rpat(wl, rl, nrx);
            end
            #1;
            if (held) check("R7 tx hold", {tx_valid, tx_data}, {1'b1, held_d});
            held = 0;
            if (in_rx) begin
                if (tx_valid) check("R6 no extra tx byte", tx_valid, 0);
                if (rx_valid) begin rb_model[nrx] = rx_data; nrx++; end
            end else if (tx_valid && tx_ready) begin
                check("R4/R5 frame byte", tx_data, exp_q[ntx]);
                ntx++;
            end else if (tx_valid) begin
                held = 1; held_d = tx_data;
            end
            if (ntx == nexp && nrx == rl) break;
            @(negedge clk);
        end
        @(negedge clk);
        reg_wr = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
        #1;
        check("R9 done pulse", {done, busy}, 2'b10);
        check("R4 all bytes sent", ntx, nexp);
        @(negedge clk); #1;
        check("R9 done one cycle", done, 0);
        for (int j = 0; j < 9; j++) begin
            reg_read(A_RB + j, rd);
            check("R8 read buffer", rd, rb_model[j]);
        end
        if (poke) begin
            reg_read(A_WB, rd);
            check("R10 write while busy ignored", rd, wpat(wl, 0));
        end
    endtask

    initial begin
        int rls [4] = '{0, 1, 5, 9};
        logic [7:0] rd;
        foreach (rb_model[j]) rb_model[j] = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 busy/done/err/tx_valid", {busy, done, err, tx_valid}, 0);
        for (int a = 0; a < 26; a++) begin
            reg_read(a, rd);
            check("R1 register reset", rd, 0);
        end
        rst_n = 1'b1;
        // R3 rejected lengths
        reg_write(1, 8'd15); reg_write(2, 8'd0); reg_write(A_CTL, 8'h01);
        #1 check("R3 wlen 15 rejected", {err, busy, tx_valid}, 3'b100);
        reg_read(A_CTL, rd); check("R2 control readback", rd, 8'h04);
        reg_write(1, 8'd2); reg_write(2, 8'd10); reg_write(A_CTL, 8'h01);
        #1 check("R3 rlen 10 rejected", {err, busy, tx_valid}, 3'b100);
        reg_write(A_RB, 8'h55);
        reg_read(A_RB, rd); check("R2 read buffer not host-writable", rd, 0);
        // R3 accepted start clears err, also R10 poke
        run_txn(3, 2, 1'b0, 1'b1);
        check("R3 err cleared", err, 0);
        for (int wl = 0; wl <= 14; wl++)
            foreach (rls[k]) run_txn(wl, rls[k], (wl + k) % 2 == 1, k == 3 && wl >= 2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule